// File: doc/BRIEF.md
# Short Forward Branch Writeback Suppressor

This block sits at the execute-to-writeback boundary of a dual-issue, in-order core. Each cycle it looks at the two issued slots. Slot A may hold a conditional branch. Slot B holds the instruction that follows it. When the branch jumps forward over exactly that one instruction, and that instruction is a plain ALU operation, the two are kept as a pair. The branch runs in the first pipe and the shadow instruction runs in the second pipe in the same cycle. Each stays its own operation; they are not merged.

When a paired branch resolves as taken, fetch is not redirected. The block instead drops the register write of the shadow instruction. When the branch is not taken, the shadow instruction writes back in the same cycle the branch completes.

Every other taken branch takes the normal path: the block raises a redirect request with the branch target and kills slot B. This covers a shadow that is a load, a store or an unsupported class, an offset that does not match, and any branch while the disable input is high. All outputs are registered one cycle after the inputs.

Top module: `sfb_pair_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `wa_we`, `wb_we` and `redirect` are all low.
- R2: A pair is formed when all of these hold: slot A is valid with class 5 (conditional branch); slot B is valid; slot B's class is 0 (register-register ALU), 1 (register-immediate ALU, including the compressed move and load-immediate aliases) or 2 (upper-immediate forms); `a_off` equals the shadow length (2 when `b_c`=1, 4 when `b_c`=0); and `b_pc` equals `a_pc` plus slot A's length (2 when `a_c`=1, else 4). A formed pair never raises `redirect`.
- R3: For a pair whose branch is taken, `wb_we` is low in the next cycle and `redirect` stays low.
- R4: For a branch that is not taken, slot B writes back normally: `wb_we` equals `b_vld & b_we` in the next cycle, with `b_rd` and `b_res` on `wb_rd` and `wb_data`.
- R5: A shadow of class 3 (load), class 4 (store) or any class above 5 is never paired. If its branch is taken, `redirect` is raised and `wb_we` is low.
- R6: A wrong offset (wrong length, larger, or backward) or a non-consecutive `b_pc` prevents pairing. A taken branch then raises `redirect` and kills slot B.
- R7: While `pair_dis` is high, every taken branch in slot A raises `redirect` and kills slot B.
- R8: All outputs change only at a rising clock edge, one cycle after the inputs that cause them.
- R9: When slot A is not a branch, nothing is redirected. Each valid slot writes back when its write-enable is set. A class-5 slot A never writes itself.
- R10: A taken branch with `b_vld` low raises `redirect`, and `wb_we` stays low.
- R11: `redirect_pc` equals `a_pc` plus the sign-extended `a_off` of the branch that raised the redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pair_dis | input | 1 | Disables pairing; all taken branches redirect |
| br_taken | input | 1 | Comparison result of the slot A branch |
| a_vld | input | 1 | Slot A valid |
| a_pc | input | XLEN | Slot A address |
| a_cls | input | 3 | Slot A class code |
| a_off | input | OFF_W | Slot A branch offset, signed |
| a_c | input | 1 | Slot A is a 2-byte instruction |
| a_rd | input | RA_W | Slot A destination register |
| a_we | input | 1 | Slot A writes a register |
| a_res | input | XLEN | Slot A result |
| b_vld | input | 1 | Slot B valid |
| b_pc | input | XLEN | Slot B address |
| b_cls | input | 3 | Slot B class code |
| b_c | input | 1 | Slot B is a 2-byte instruction |
| b_rd | input | RA_W | Slot B destination register |
| b_we | input | 1 | Slot B writes a register |
| b_res | input | XLEN | Slot B result |
| wa_we | output | 1 | Pipe A register write enable |
| wa_rd | output | RA_W | Pipe A destination |
| wa_data | output | XLEN | Pipe A write data |
| wb_we | output | 1 | Pipe B register write enable after gating |
| wb_rd | output | RA_W | Pipe B destination |
| wb_data | output | XLEN | Pipe B write data |
| redirect | output | 1 | Fetch redirect request |
| redirect_pc | output | XLEN | Redirect target |

## Verification
The bench starts with directed pairs. It uses full-size and compressed shadows of each qualifying class, with the branch both taken and not taken. This shows that a taken pair suppresses the shadow write and does not redirect. The same pairs are then repeated with one thing spoiled each time: a load or store shadow, an offset off by one length, a backward offset, a gap in `b_pc`, the disable bit set, or an empty slot B. Each of these must flip the outcome to a redirect with the correct target. A long stream of mixed random slots, biased toward near-eligible pairs, then checks the gating of both write enables against the behavioural model every cycle.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
  typedef enum logic [2:0] {
    CLS_ALU_RR = 3'd0,
    CLS_ALU_RI = 3'd1,
    CLS_UPPER  = 3'd2,
    CLS_LOAD   = 3'd3,
    CLS_STORE  = 3'd4,
    CLS_BRANCH = 3'd5,
    CLS_JUMP   = 3'd6,
    CLS_OTHER  = 3'd7
  } cls_e;

  localparam int unsigned LEN_HALF = 2;
  localparam int unsigned LEN_FULL = 4;
endpackage

// File: rtl/sfb_elig.sv
module sfb_elig
  import sfb_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned OFF_W    = 13,
  parameter bit          EN_UPPER = 1'b1
) (
  input  logic             dis,
  input  logic             a_vld,
  input  logic [2:0]       a_cls,
  input  logic [XLEN-1:0]  a_pc,
  input  logic [OFF_W-1:0] a_off,
  input  logic             a_c,
  input  logic             b_vld,
  input  logic [XLEN-1:0]  b_pc,
  input  logic [2:0]       b_cls,
  input  logic             b_c,
  output logic             pair
);
  logic             shadow_ok;
  logic [OFF_W-1:0] need_off;
  logic [XLEN-1:0]  next_pc;

  generate
    if (EN_UPPER) begin : g_upper
      always_comb shadow_ok = (b_cls == CLS_ALU_RR) || (b_cls == CLS_ALU_RI) ||
                              (b_cls == CLS_UPPER);
    end else begin : g_no_upper
      always_comb shadow_ok = (b_cls == CLS_ALU_RR) || (b_cls == CLS_ALU_RI);
    end
  endgenerate

  always_comb begin
    need_off = b_c ? OFF_W'(LEN_HALF) : OFF_W'(LEN_FULL);
    next_pc  = a_pc + (a_c ? XLEN'(LEN_HALF) : XLEN'(LEN_FULL));
    pair     = !dis && a_vld && (a_cls == CLS_BRANCH) && b_vld && shadow_ok &&
               (a_off == need_off) && (b_pc == next_pc);
  end
endmodule

// File: rtl/sfb_wb_reg.sv
module sfb_wb_reg #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned RA_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vld,
  input  logic            we,
  input  logic            kill,
  input  logic [RA_W-1:0] rd,
  input  logic [XLEN-1:0] data,
  output logic            we_q,
  output logic [RA_W-1:0] rd_q,
  output logic [XLEN-1:0] data_q
);
  logic we_d;
  logic ld_en;

  always_comb begin
    we_d  = vld && we && !kill;
    ld_en = vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b0;
    else        we_q <= we_d;
  end

  always_ff @(posedge clk) begin
    if (ld_en) begin
      rd_q   <= rd;
      data_q <= data;
    end
  end
endmodule

// File: rtl/sfb_pair_ctrl.sv
module sfb_pair_ctrl
  import sfb_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned OFF_W    = 13,
  parameter int unsigned RA_W     = 5,
  parameter bit          EN_UPPER = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pair_dis,
  input  logic             br_taken,
  input  logic             a_vld,
  input  logic [XLEN-1:0]  a_pc,
  input  logic [2:0]       a_cls,
  input  logic [OFF_W-1:0] a_off,
  input  logic             a_c,
  input  logic [RA_W-1:0]  a_rd,
  input  logic             a_we,
  input  logic [XLEN-1:0]  a_res,
  input  logic             b_vld,
  input  logic [XLEN-1:0]  b_pc,
  input  logic [2:0]       b_cls,
  input  logic             b_c,
  input  logic [RA_W-1:0]  b_rd,
  input  logic             b_we,
  input  logic [XLEN-1:0]  b_res,
  output logic             wa_we,
  output logic [RA_W-1:0]  wa_rd,
  output logic [XLEN-1:0]  wa_data,
  output logic             wb_we,
  output logic [RA_W-1:0]  wb_rd,
  output logic [XLEN-1:0]  wb_data,
  output logic             redirect,
  output logic [XLEN-1:0]  redirect_pc
);
  localparam int unsigned NSLOT = 2;
  localparam int unsigned EXT_W = XLEN - OFF_W;

  logic pair;
  logic a_br;
  logic redir_d;
  logic [XLEN-1:0] tgt_d;

  logic [NSLOT-1:0] s_vld, s_we, s_kill, s_we_q;
  logic [RA_W-1:0]  s_rd   [NSLOT];
  logic [XLEN-1:0]  s_dat  [NSLOT];
  logic [RA_W-1:0]  s_rd_q [NSLOT];
  logic [XLEN-1:0]  s_dat_q[NSLOT];

  sfb_elig #(.XLEN(XLEN), .OFF_W(OFF_W), .EN_UPPER(EN_UPPER)) u_elig (
    .dis(pair_dis), .a_vld(a_vld), .a_cls(a_cls), .a_pc(a_pc), .a_off(a_off),
    .a_c(a_c), .b_vld(b_vld), .b_pc(b_pc), .b_cls(b_cls), .b_c(b_c), .pair(pair)
  );

  // Next-state for the control path
  always_comb begin
    a_br    = a_vld && (a_cls == CLS_BRANCH);
    redir_d = a_br && br_taken && !pair;
    tgt_d   = a_pc + {{EXT_W{a_off[OFF_W-1]}}, a_off};
    s_vld   = {b_vld, a_vld};
    s_we    = {b_we, a_we};
    s_kill  = {a_br && br_taken, a_cls == CLS_BRANCH};
    s_rd[0] = a_rd;  s_dat[0] = a_res;
    s_rd[1] = b_rd;  s_dat[1] = b_res;
  end

  generate
    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      sfb_wb_reg #(.XLEN(XLEN), .RA_W(RA_W)) u_wb (
        .clk(clk), .rst_n(rst_n), .vld(s_vld[i]), .we(s_we[i]), .kill(s_kill[i]),
        .rd(s_rd[i]), .data(s_dat[i]),
        .we_q(s_we_q[i]), .rd_q(s_rd_q[i]), .data_q(s_dat_q[i])
      );
    end
  endgenerate

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) redirect <= 1'b0;
    else        redirect <= redir_d;
  end

  always_ff @(posedge clk) begin
    if (redir_d) redirect_pc <= tgt_d;
  end

  always_comb begin
    wa_we   = s_we_q[0];
    wa_rd   = s_rd_q[0];
    wa_data = s_dat_q[0];
    wb_we   = s_we_q[1];
    wb_rd   = s_rd_q[1];
    wb_data = s_dat_q[1];
  end

  AST_PAIR_NO_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    pair |=> !redirect); // R2
  AST_TAKEN_KILLS_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    (a_br && br_taken) |=> !wb_we); // R3
  AST_NOT_TAKEN_KEEPS_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    (a_br && !br_taken && b_vld && b_we) |=> wb_we); // R4
  AST_DISABLE_FORCES_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_dis && a_br && br_taken) |=> redirect); // R7
  AST_BAD_SHADOW_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (a_br && br_taken && b_vld && (b_cls == CLS_LOAD || b_cls == CLS_STORE)) |=> redirect); // R5
  AST_REDIRECT_FROM_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> $past(a_vld && a_cls == CLS_BRANCH && br_taken)); // R9
endmodule

// File: tb/sim_sfb_pair_ctrl.sv
`timescale 1ns/1ps
module sim_sfb_pair_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic pair_dis, br_taken;
  logic a_vld, a_c, a_we, b_vld, b_c, b_we;
  logic [31:0] a_pc, b_pc, a_res, b_res;
  logic [2:0]  a_cls, b_cls;
  logic [12:0] a_off;
  logic [4:0]  a_rd, b_rd;
  logic wa_we, wb_we, redirect;
  logic [4:0]  wa_rd, wb_rd;
  logic [31:0] wa_data, wb_data, redirect_pc;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit prev_redir = 0, prev_wbwe = 0, prev_wawe = 0;

  always #2 clk = ~clk;

  sfb_pair_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .pair_dis(pair_dis), .br_taken(br_taken),
    .a_vld(a_vld), .a_pc(a_pc), .a_cls(a_cls), .a_off(a_off), .a_c(a_c),
    .a_rd(a_rd), .a_we(a_we), .a_res(a_res),
    .b_vld(b_vld), .b_pc(b_pc), .b_cls(b_cls), .b_c(b_c), .b_rd(b_rd),
    .b_we(b_we), .b_res(b_res),
    .wa_we(wa_we), .wa_rd(wa_rd), .wa_data(wa_data),
    .wb_we(wb_we), .wb_rd(wb_rd), .wb_data(wb_data),
    .redirect(redirect), .redirect_pc(redirect_pc)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic drive(input bit dis, input bit tk,
                       input bit av, input int acls, input int aoff, input bit ac,
                       input bit bv, input int bcls, input bit bc, input int gap,
                       input bit awe, input bit bwe);
    pair_dis = dis; br_taken = tk;
    a_vld = av; a_cls = 3'(acls); a_off = 13'(aoff); a_c = ac;
    a_pc = {$urandom(), 1'b0}; a_rd = 5'($urandom()); a_we = awe; a_res = $urandom();
    b_vld = bv; b_cls = 3'(bcls); b_c = bc;
    b_pc = a_pc + 32'(ac ? 2 : 4) + 32'(gap);
    b_rd = 5'($urandom()); b_we = bwe; b_res = $urandom();
  endtask

  // Behavioural reference: one step = drive at negedge, compare at next negedge
  task automatic step();
    bit isbr, okcls, pr, e_wa, e_wb, e_rd;
    int lenb;
    logic [31:0] e_tgt;
    string t_red, t_wb;
    logic [4:0] ard, brd;
    logic [31:0] ares, bres;
    isbr  = a_vld && (a_cls == 3'd5);
    lenb  = b_c ? 2 : 4;
    okcls = (b_cls == 3'd0) || (b_cls == 3'd1) || (b_cls == 3'd2);
    pr    = !pair_dis && isbr && b_vld && okcls &&
            ($signed(a_off) == lenb) && (b_pc == a_pc + (a_c ? 32'd2 : 32'd4));
    e_wa  = a_vld && a_we && (a_cls != 3'd5);
    e_wb  = b_vld && b_we && !(isbr && br_taken);
    e_rd  = isbr && br_taken && !pr;
    e_tgt = a_pc + 32'($signed(a_off));
    if (!isbr)               begin t_red = "R9";  t_wb = "R9";  end
    else if (pair_dis)       begin t_red = "R7";  t_wb = "R7";  end
    else if (!b_vld)         begin t_red = "R10"; t_wb = "R10"; end
    else if (pr)             begin t_red = "R2";  t_wb = br_taken ? "R3" : "R4"; end
    else if (!okcls)         begin t_red = "R5";  t_wb = br_taken ? "R5" : "R4"; end
    else                     begin t_red = "R6";  t_wb = br_taken ? "R6" : "R4"; end
    ard = a_rd; brd = b_rd; ares = a_res; bres = b_res;
    #1;
    chk("R8", "redirect before edge", 32'(redirect), 32'(prev_redir));
    chk("R8", "wb_we before edge", 32'(wb_we), 32'(prev_wbwe));
    chk("R8", "wa_we before edge", 32'(wa_we), 32'(prev_wawe));
    @(negedge clk);
    chk(t_red, "redirect", 32'(redirect), 32'(e_rd));
    if (e_rd) chk("R11", "redirect_pc", redirect_pc, e_tgt);
    chk(t_wb, "wb_we", 32'(wb_we), 32'(e_wb));
    if (e_wb) begin
      chk("R4", "wb_rd", 32'(wb_rd), 32'(brd));
      chk("R4", "wb_data", wb_data, bres);
    end
    chk("R9", "wa_we", 32'(wa_we), 32'(e_wa));
    if (e_wa) begin
      chk("R9", "wa_rd", 32'(wa_rd), 32'(ard));
      chk("R9", "wa_data", wa_data, ares);
    end
    prev_redir = e_rd; prev_wbwe = e_wb; prev_wawe = e_wa;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(0, 1, 1, 5, 8, 0, 1, 0, 0, 0, 1, 1);
    repeat (3) @(negedge clk);
    chk("R1", "redirect in reset", 32'(redirect), 32'd0);
    chk("R1", "wa_we in reset", 32'(wa_we), 32'd0);
    chk("R1", "wb_we in reset", 32'(wb_we), 32'd0);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "redirect after reset", 32'(redirect), 32'd0);
    chk("R1", "wb_we after reset", 32'(wb_we), 32'd0);

    // dis tk av acls off ac bv bcls bc gap awe bwe
    drive(0, 1, 1, 5, 4, 0, 1, 0, 0, 0, 0, 1); step(); // R3 full RR taken
    drive(0, 0, 1, 5, 4, 0, 1, 0, 0, 0, 0, 1); step(); // R4 not taken
    drive(0, 1, 1, 5, 2, 1, 1, 1, 1, 0, 0, 1); step(); // R3 compressed alias
    drive(0, 0, 1, 5, 2, 0, 1, 1, 1, 0, 0, 1); step(); // R4 compressed
    drive(0, 1, 1, 5, 4, 1, 1, 2, 0, 0, 0, 1); step(); // R3 upper-immediate
    drive(0, 1, 1, 5, 4, 0, 1, 3, 0, 0, 0, 1); step(); // R5 load
    drive(0, 1, 1, 5, 4, 0, 1, 4, 0, 0, 0, 0); step(); // R5 store
    drive(0, 0, 1, 5, 4, 0, 1, 3, 0, 0, 0, 1); step(); // R4 load not taken
    drive(0, 1, 1, 5, 4, 0, 1, 7, 0, 0, 0, 1); step(); // R5 other class
    drive(0, 1, 1, 5, 4, 0, 1, 0, 1, 0, 0, 1); step(); // R6 off 4 vs 2-byte
    drive(0, 1, 1, 5, 2, 0, 1, 0, 0, 0, 0, 1); step(); // R6 off 2 vs 4-byte
    drive(0, 1, 1, 5, 8, 0, 1, 0, 0, 0, 0, 1); step(); // R6 longer skip
    drive(0, 1, 1, 5, -4, 0, 1, 0, 0, 0, 0, 1); step(); // R6 backward, R11
    drive(0, 1, 1, 5, 4, 0, 1, 0, 0, 2, 0, 1); step(); // R6 pc gap
    drive(1, 1, 1, 5, 4, 0, 1, 0, 0, 0, 0, 1); step(); // R7 disabled
    drive(1, 0, 1, 5, 4, 0, 1, 0, 0, 0, 0, 1); step(); // R7 disabled not taken
    drive(0, 1, 1, 0, 4, 0, 1, 0, 0, 0, 1, 1); step(); // R9 ALU in slot A
    drive(0, 1, 1, 6, 4, 0, 1, 0, 0, 0, 1, 1); step(); // R9 jump in slot A
    drive(0, 1, 1, 5, 4, 0, 0, 0, 0, 0, 0, 1); step(); // R10 empty slot B
    drive(0, 1, 1, 5, 4, 0, 1, 0, 0, 0, 0, 1); step(); // R3 back-to-back
    drive(0, 1, 1, 5, 4, 0, 1, 0, 0, 0, 0, 1); step();

    for (int n = 0; n < 4000; n++) begin
      int offs[6] = '{2, 4, 8, -4, 6, 0};
      int ac_r = $urandom_range(0, 1);
      int bc_r = $urandom_range(0, 1);
      int off  = ($urandom_range(0, 3) != 0) ? (bc_r ? 2 : 4) : offs[$urandom_range(0, 5)];
      drive($urandom_range(0, 9) == 0, $urandom_range(0, 1) == 1,
            $urandom_range(0, 7) != 0,
            ($urandom_range(0, 2) != 0) ? 5 : int'($urandom_range(0, 7)),
            off, 1'(ac_r), $urandom_range(0, 7) != 0, int'($urandom_range(0, 7)), 1'(bc_r),
            ($urandom_range(0, 7) == 0) ? 2 : 0,
            $urandom_range(0, 1) == 1, $urandom_range(0, 3) != 0);
      step();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule